// File: doc/BRIEF.md
# Programmable Video Timing-Code Event Matcher

This block sits behind a timing-code detector in a video capture path. Each time the detector has found a start-of-line or end-of-line timing code, it presents the code's three flag bits for one cycle: the horizontal flag (H), the vertical-blanking flag (V) and the field flag (F). The matcher compares those flags with programmable three-bit patterns and turns them into named events: start and end of active video, and start and end of a first and a second blanking region.

The patterns sit in two 21-bit configuration words, each holding six patterns in a fixed layout. The F flag of the incoming code picks which word is consulted. Swapping the two words therefore changes which patterns apply to which field. A single registered stage produces one-cycle event pulses, a flag telling whether the stream is in active video or in blanking, and the field of the last code that produced an event. When several patterns in the selected word match the same code, a fixed priority picks exactly one event.

Top module: `avcode_event_matcher`

## Requirements
- R1: A pattern is three bits holding H, V and F from most to least significant. Within a configuration word the slots are: start-active in bits 20:18, end-active in 17:15, second-blanking start in 11:9, second-blanking end in 8:6, first-blanking start in 5:3 and first-blanking end in 2:0. Bits 14:12 have no effect.
- R2: A code with F=1 is compared against `cfg_word0`, and a code with F=0 against `cfg_word1`. Swapping the words swaps which patterns apply to which field.
- R3: A matching code accepted at a clock edge raises exactly one bit of `evt_pulse` after that edge, for one cycle only. The bits are: 0 end-active, 1 start-active, 2 first-blanking end, 3 first-blanking start, 4 second-blanking end, 5 second-blanking start.
- R4: When several slots match one code, only the highest-priority event fires. The priority, from highest to lowest, is end-active, start-active, first-blanking end, first-blanking start, second-blanking end, second-blanking start.
- R5: A blanking slot holding 000 is unused and never matches. Active slots match on every value, 000 included, so an empty blanking slot never stands in the way of an active event on the same code.
- R6: While `code_vld` is low, `evt_pulse` is zero the next cycle, and `in_active` and `cur_field` keep their values.
- R7: `in_active` goes to 1 with a start-active event and to 0 with any other event, changing in the same cycle as the pulse.
- R8: `cur_field` takes the F flag of each code that produces an event, in the same cycle as the pulse.
- R9: After a synchronous reset, `evt_pulse` is zero, `in_active` is 0 and `cur_field` is 0.
- R10: A valid code that matches no enabled slot produces no event and leaves `in_active` and `cur_field` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code_vld | input | 1 | A decoded timing code is present this cycle |
| code_h | input | 1 | H flag of the code (1 at end of line) |
| code_v | input | 1 | V flag of the code (1 in vertical blanking) |
| code_f | input | 1 | F flag of the code (field); selects the configuration word |
| cfg_word0 | input | 21 | Patterns used for codes with F=1 |
| cfg_word1 | input | 21 | Patterns used for codes with F=0 |
| evt_pulse | output | 6 | One-cycle event pulses, at most one bit set |
| in_active | output | 1 | 1 while in active video, 0 in blanking |
| cur_field | output | 1 | F flag of the last code that produced an event |

## Verification
An error in word selection, slot extraction or priority shows on `evt_pulse` in the cycle right after the offending code: a wrong bit, two bits, or no bit at all. Region and field state are registered, so a wrong update is seen on `in_active` or `cur_field` in the same cycle as the pulse. It also persists until the next event rewrites it, so every later check of the state catches it too. The stimulus covers interlaced and progressive configurations, an empty second blanking slot pair, colliding patterns and swapped field words. This lets a slot read from the wrong bits, or a reversed priority, change an observed pulse.

// File: rtl/avm_pkg.sv
package avm_pkg;

    localparam int PAT_W  = 3;
    localparam int CFG_W  = 21;
    localparam int NUM_EV = 6;

    // Event indices, listed from highest to lowest priority.
    typedef enum logic [2:0] {
        EV_ACT_END   = 3'd0,
        EV_ACT_START = 3'd1,
        EV_B1_END    = 3'd2,
        EV_B1_START  = 3'd3,
        EV_B2_END    = 3'd4,
        EV_B2_START  = 3'd5
    } ev_e;

    typedef struct packed {
        logic h;
        logic v;
        logic f;
    } hvf_t;

    typedef logic [NUM_EV-1:0][PAT_W-1:0] pat_set_t;
    typedef logic [NUM_EV-1:0]            ev_vec_t;

    // Least significant bit of each event's slot inside a configuration word.
    function automatic int slot_lsb(input int idx);
        case (idx)
            0:       return 15;  // end-active
            1:       return 18;  // start-active
            2:       return 0;   // first-blanking end
            3:       return 3;   // first-blanking start
            4:       return 6;   // second-blanking end
            default: return 9;   // second-blanking start
        endcase
    endfunction

    // Blanking slots may be left empty; active slots may not.
    function automatic bit is_blank_slot(input int idx);
        return idx >= 2;
    endfunction

endpackage

// File: rtl/avm_slot_unpack.sv
module avm_slot_unpack
    import avm_pkg::*;
#(
    parameter int W_CFG = CFG_W,
    parameter int W_PAT = PAT_W,
    parameter int N_EV  = NUM_EV
) (
    input  logic [W_CFG-1:0]            cfg,
    output logic [N_EV-1:0][W_PAT-1:0]  pats
);

    for (genvar i = 0; i < N_EV; i++) begin : g_slot
        localparam int LSB = slot_lsb(i);
        assign pats[i] = cfg[LSB +: W_PAT];
    end

endmodule

// File: rtl/avm_slot_match.sv
module avm_slot_match
    import avm_pkg::*;
#(
    parameter int W_PAT = PAT_W,
    parameter int N_EV  = NUM_EV
) (
    input  logic [W_PAT-1:0]            code,
    input  logic [N_EV-1:0][W_PAT-1:0]  pats,
    output logic [N_EV-1:0]             hit
);

    for (genvar i = 0; i < N_EV; i++) begin : g_cmp
        if (is_blank_slot(i)) begin : g_blank
            // An all-zero blanking slot is treated as unused.
            assign hit[i] = (pats[i] != '0) && (pats[i] == code);
        end else begin : g_active
            assign hit[i] = (pats[i] == code);
        end
    end

endmodule

// File: rtl/avm_prio_pick.sv
module avm_prio_pick #(
    parameter int N_EV = 6
) (
    input  logic [N_EV-1:0] req,
    output logic [N_EV-1:0] grant
);

    // The lowest index wins.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < N_EV; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/avcode_event_matcher.sv
module avcode_event_matcher
    import avm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              code_vld,
    input  logic              code_h,
    input  logic              code_v,
    input  logic              code_f,
    input  logic [CFG_W-1:0]  cfg_word0,
    input  logic [CFG_W-1:0]  cfg_word1,
    output logic [NUM_EV-1:0] evt_pulse,
    output logic              in_active,
    output logic              cur_field
);

    hvf_t               code;
    logic [CFG_W-1:0]   cfg_sel;
    pat_set_t           pats;
    ev_vec_t            hits;
    ev_vec_t            win;
    ev_vec_t            evt_q;
    logic               act_q;
    logic               fld_q;

    assign code    = '{h: code_h, v: code_v, f: code_f};
    assign cfg_sel = code.f ? cfg_word0 : cfg_word1;

    avm_slot_unpack #(.W_CFG(CFG_W), .W_PAT(PAT_W), .N_EV(NUM_EV)) u_unpack (
        .cfg  (cfg_sel),
        .pats (pats)
    );

    avm_slot_match #(.W_PAT(PAT_W), .N_EV(NUM_EV)) u_match (
        .code (code),
        .pats (pats),
        .hit  (hits)
    );

    avm_prio_pick #(.N_EV(NUM_EV)) u_prio (
        .req   (hits),
        .grant (win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= '0;
            act_q <= 1'b0;
            fld_q <= 1'b0;
        end else begin
            evt_q <= code_vld ? win : '0;
            if (code_vld && (win != '0)) begin
                act_q <= win[EV_ACT_START];
                fld_q <= code.f;
            end
        end
    end

    assign evt_pulse = evt_q;
    assign in_active = act_q;
    assign cur_field = fld_q;

endmodule

// File: rtl/avm_checker.sv
module avm_checker
    import avm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              code_vld,
    input logic              code_f,
    input logic [NUM_EV-1:0] evt_pulse,
    input logic              in_active,
    input logic              cur_field
);

    p_single_event_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_pulse));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> (evt_pulse == '0));

    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !code_vld |=> ($stable(in_active) && $stable(cur_field)));

    p_active_set_r7: assert property (@(posedge clk) disable iff (rst)
        evt_pulse[EV_ACT_START] |-> in_active);

    p_active_clr_r7: assert property (@(posedge clk) disable iff (rst)
        ((evt_pulse != '0) && !evt_pulse[EV_ACT_START]) |-> !in_active);

    p_field_track_r8: assert property (@(posedge clk) disable iff (rst)
        code_vld |=> ((evt_pulse == '0) || (cur_field == $past(code_f))));

    p_pulse_once_r3: assert property (@(posedge clk) disable iff (rst)
        ((evt_pulse != '0) && !code_vld) |=> (evt_pulse == '0));

endmodule

bind avcode_event_matcher avm_checker u_avm_checker (
    .clk       (clk),
    .rst       (rst),
    .code_vld  (code_vld),
    .code_f    (code_f),
    .evt_pulse (evt_pulse),
    .in_active (in_active),
    .cur_field (cur_field)
);

// File: tb/test_avcode_event_matcher.sv
`timescale 1ns/1ps
module test_avcode_event_matcher;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        code_vld = 1'b0;
    logic [2:0]  hvf = 3'b000;
    logic [20:0] w0 = '0;
    logic [20:0] w1 = '0;
    logic [5:0]  evt_pulse;
    logic        in_active;
    logic        cur_field;

    int n_chk = 0;
    int n_bad = 0;
    logic m_act = 1'b0;
    logic m_fld = 1'b0;

    always #4 clk = ~clk;

    avcode_event_matcher i_avcode_event_matcher (
        .clk       (clk),
        .rst       (rst),
        .code_vld  (code_vld),
        .code_h    (hvf[2]),
        .code_v    (hvf[1]),
        .code_f    (hvf[0]),
        .cfg_word0 (w0),
        .cfg_word1 (w1),
        .evt_pulse (evt_pulse),
        .in_active (in_active),
        .cur_field (cur_field)
    );

    // Build a word from the slot layout of R1; the unused bits are set to ones.
    function automatic logic [20:0] mkw(input logic [2:0] sa, ea, b2s, b2e, b1s, b1e);
        return {sa, ea, 3'b111, b2s, b2e, b1s, b1e};
    endfunction

    localparam logic [20:0] F1_PATS = 21'(mkw(3'b001, 3'b101, 3'b011, 3'b111, 3'b011, 3'b111));
    localparam logic [20:0] F0_PATS = 21'(mkw(3'b000, 3'b100, 3'b010, 3'b110, 3'b010, 3'b110));
    localparam logic [20:0] F0_PROG = 21'(mkw(3'b000, 3'b100, 3'b000, 3'b000, 3'b110, 3'b000));
    localparam logic [20:0] F0_B2   = 21'(mkw(3'b000, 3'b100, 3'b010, 3'b110, 3'b000, 3'b000));
    localparam logic [20:0] F0_ZERO = 21'(mkw(3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b000));

    // Entry: {configuration id, code HVF, expected evt_pulse}
    localparam int NV = 22;
    localparam logic [11:0] TBL [NV] = '{
        {3'd0, 3'b001, 6'h02}, {3'd0, 3'b101, 6'h01}, {3'd0, 3'b011, 6'h08},
        {3'd0, 3'b111, 6'h04}, {3'd0, 3'b000, 6'h02}, {3'd0, 3'b100, 6'h01},
        {3'd0, 3'b010, 6'h08}, {3'd0, 3'b110, 6'h04},
        {3'd1, 3'b000, 6'h02}, {3'd1, 3'b100, 6'h01}, {3'd1, 3'b110, 6'h08},
        {3'd1, 3'b010, 6'h00}, {3'd1, 3'b001, 6'h02},
        {3'd2, 3'b010, 6'h20}, {3'd2, 3'b110, 6'h10}, {3'd2, 3'b000, 6'h02},
        {3'd3, 3'b000, 6'h01}, {3'd3, 3'b010, 6'h00},
        {3'd4, 3'b001, 6'h00}, {3'd4, 3'b000, 6'h00}, {3'd4, 3'b101, 6'h00},
        {3'd0, 3'b011, 6'h08}
    };

    task automatic set_cfg(input logic [2:0] id);
        case (id)
            3'd0: begin w0 = F1_PATS; w1 = F0_PATS; end
            3'd1: begin w0 = F1_PATS; w1 = F0_PROG; end
            3'd2: begin w0 = F1_PATS; w1 = F0_B2;   end
            3'd3: begin w0 = F1_PATS; w1 = F0_ZERO; end
            default: begin w0 = F0_PATS; w1 = F1_PATS; end
        endcase
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " in_active"}, {7'd0, in_active}, {7'd0, m_act});
        chk({tag, " cur_field"}, {7'd0, cur_field}, {7'd0, m_fld});
    endtask

    // Present one code for one cycle, then sample at the following falling edge.
    task automatic apply(input logic [2:0] code, input logic [5:0] exp, input string tag);
        @(negedge clk);
        hvf = code;
        code_vld = 1'b1;
        @(negedge clk);
        code_vld = 1'b0;
        if (exp != 6'h00) begin
            m_act = (exp == 6'h02);
            m_fld = code[0];
        end
        chk(tag, {2'b00, evt_pulse}, {2'b00, exp});
        chk_state(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        set_cfg(3'd0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk("R9 reset evt", {2'b00, evt_pulse}, 8'h00);
        chk_state("R9 reset");

        // Table walk: R1 layout, R2 selection, R3 mapping, R4 priority, R5 empty slots, R10
        for (int i = 0; i < NV; i++) begin
            set_cfg(TBL[i][11:9]);
            apply(TBL[i][8:6], TBL[i][5:0], $sformatf("R3 R4 vector %0d", i));
        end

        // R1: unused bits 14:12 have no effect
        set_cfg(3'd0);
        w0[14:12] = 3'b000;
        apply(3'b101, 6'h01, "R1 unused bits cleared");
        w0[14:12] = 3'b101;
        apply(3'b001, 6'h02, "R1 unused bits mixed");

        // R2: a swapped configuration makes the other field's patterns apply
        set_cfg(3'd4);
        apply(3'b001, 6'h00, "R2 swapped no match");
        w0 = F1_PATS;
        apply(3'b001, 6'h02, "R2 field1 word restored");

        // R3: pulse lasts a single cycle
        set_cfg(3'd0);
        apply(3'b111, 6'h04, "R3 pulse");
        @(negedge clk);
        chk("R3 pulse gone", {2'b00, evt_pulse}, 8'h00);

        // R3: back-to-back codes give back-to-back pulses
        @(negedge clk);
        hvf = 3'b001; code_vld = 1'b1;
        @(negedge clk);
        hvf = 3'b101;
        chk("R3 back-to-back first", {2'b00, evt_pulse}, 8'h02);
        @(negedge clk);
        code_vld = 1'b0;
        m_act = 1'b0; m_fld = 1'b1;
        chk("R3 back-to-back second", {2'b00, evt_pulse}, 8'h01);
        chk_state("R7 after back-to-back");

        // R7, R8: field and region follow events
        apply(3'b000, 6'h02, "R7 R8 start active field0");
        apply(3'b010, 6'h08, "R7 R8 blank start field0");

        // R6: a matching code without valid is ignored
        apply(3'b000, 6'h02, "R6 setup active");
        @(negedge clk);
        hvf = 3'b101;
        @(negedge clk);
        chk("R6 no valid no event", {2'b00, evt_pulse}, 8'h00);
        chk_state("R6 state held");

        // R10: non-matching valid code leaves state alone
        set_cfg(3'd1);
        apply(3'b010, 6'h00, "R10 no match");

        // R5: empty blanking slot does not block start-active on 000
        apply(3'b000, 6'h02, "R5 empty blank slot");

        // R9: mid-run reset clears state
        apply(3'b001, 6'h02, "R9 pre-reset active");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_act = 1'b0; m_fld = 1'b0;
        chk("R9 mid reset evt", {2'b00, evt_pulse}, 8'h00);
        chk_state("R9 mid reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule